// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the horizontal sync, vertical sync, composite sync and data-enable strobes for a raster display. It also brings out the current pixel and line position, a field flag and a one-cycle pulse at the end of each field's active region. The pixel and line counters count from the top-left pixel of the visible area, so position (0,0) is the first active pixel. Blanking, sync and the porches all follow the visible region.

Software programs the geometry with packed 32-bit configuration words, described once for the even (or progressive) field. In interlaced mode the block derives the odd field's parameters itself and alternates between the two field sets at every field boundary, so nothing needs reprogramming per vertical sync. The odd field gets one extra line and one extra line before vertical sync, keeps the same lines after it, and shifts its vertical-sync pixel position half a line earlier. All configuration, including the sync inversion bits, is captured into shadow registers while the block is disabled and again at the end of every field. Each field therefore runs on one consistent parameter set.

Top module: `interlace_timing_gen`

## Requirements
- R1: While `enable` is high, `pixX` advances by one every clock from 0 to htot-1. At each line wrap `pixY` advances by one, and after the field's last line both counters return to 0. While `enable` is low both counters read 0.
- R2: `de` is high exactly when enabled with `pixX` < hact and `pixY` < vact, where `cfgActive` = {vact[31:16], hact[15:0]}. `blank` is always the complement of `de`.
- R3: The uninverted horizontal sync is active for `pixX` from hact+right up to but excluding htot-left. Here `cfgHPorch` = {left[31:16], right[15:0]} and `cfgTotal` = {vtot[31:16], htot[15:0]}.
- R4: In an even or progressive field the field lasts vtot lines. `cfgVPorch` = {front[31:16], back[15:0]}. The uninverted vertical sync starts at line vact+back, pixel ON and stops at line vtot-front, pixel OFF, exclusive. `cfgVsyncPos` holds ON in bits [31:20], OFF in bits [11:0] and an offset enable in bit 16. When bit 16 is 0, ON and OFF are both pixel 0.
- R5: In an odd field the field lasts vtot+1 lines. Vertical sync starts at line vact+back+1 and stops at line vtot+1-front, so the number of lines after sync is unchanged. When the offset is enabled, ON and OFF are each reduced by floor(htot/2).
- R6: `fieldOdd` is 0 after reset and while disabled, so the first field after enabling is even. At each field end it toggles if `interlaced` is high and otherwise becomes 0.
- R7: The uninverted syncs are active high, and composite sync is horizontal OR vertical sync. `cfgInvert` bit 0 inverts `hsync`, bit 1 inverts `vsync` and bit 2 inverts `csync`.
- R8: Configuration inputs are sampled on every clock while disabled and on the last pixel of each field. A change made mid-field has no effect until the first line of the next field.
- R9: `frameDone` is high for exactly the one clock at the last pixel of line vact-1 in every field.
- R10: While disabled, `de` is 0, `blank` is 1, `fieldOdd` is 0 and every sync sits at its inactive level.
- R11: With htot 2640, hsync start 2448 and both sync positions at 2448, vertical sync rises at pixel 2448 in the even field and at pixel 1128 in the odd field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the raster; low holds counters at the origin |
| interlaced | input | 1 | Alternate even and odd field parameter sets |
| cfgActive | input | 32 | {vact, hact} |
| cfgHPorch | input | 32 | {left margin, right margin} |
| cfgVPorch | input | 32 | {lines after sync, lines before sync} |
| cfgTotal | input | 32 | {vtot, htot} |
| cfgVsyncPos | input | 32 | Vertical-sync pixel positions and offset enable |
| cfgInvert | input | 3 | Invert bits for hsync, vsync, csync |
| pixX | output | CW (12) | Pixel position within the line |
| pixY | output | CW (12) | Line position within the field |
| de | output | 1 | Data enable |
| blank | output | 1 | High outside the visible area |
| hsync | output | 1 | Horizontal sync after inversion |
| vsync | output | 1 | Vertical sync after inversion |
| csync | output | 1 | Composite sync after inversion |
| fieldOdd | output | 1 | High during an odd field |
| frameDone | output | 1 | One-clock pulse at the end of the last active line |

## Verification
The embedded assertions watch the invariants that hold on every clock: the pixel counter stays below the line total, the line counter moves only at a line wrap, both counters sit at the origin while disabled, `frameDone` never lasts two clocks, and the field flag changes only at a field boundary and never turns odd in progressive mode. The bench's reference model compares every output on every clock. Only its scenarios can show where vertical sync lands in each field, that odd fields are one line longer, that a mid-field configuration change is deferred to the next field, and that the half-line shift lands on pixel 1128 for the 2640-clock line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int VSPOS_ON_LSB = 20;
  localparam int VSPOS_EN_BIT = 16;
  localparam int VSPOS_W      = 12;

  typedef struct packed {
    logic run;
    logic loadCfg;
    logic lineWrap;
    logic fieldWrap;
    logic oddField;
  } vtgStrobe_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       interlaced,
  input  logic       lineEnd,
  input  logic       fieldEnd,
  output vtgStrobe_t strobe
);
  logic oddQ;
  logic lineWrapW;
  logic fieldWrapW;

  assign lineWrapW  = enable && lineEnd;
  assign fieldWrapW = lineWrapW && fieldEnd;

  always_comb begin
    strobe.run       = enable;
    strobe.lineWrap  = lineWrapW;
    strobe.fieldWrap = fieldWrapW;
    strobe.loadCfg   = !enable || fieldWrapW;
    strobe.oddField  = oddQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           oddQ <= 1'b0;
    else if (!enable)    oddQ <= 1'b0;
    else if (fieldWrapW) oddQ <= interlaced ? ~oddQ : 1'b0;
  end

  // R6
  field_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && (oddQ != $past(oddQ))) |-> $past(fieldWrapW));

  // R6
  progressive_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fieldWrapW && !interlaced) |=> !oddQ);
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  vtgStrobe_t    strobe,
  input  logic [31:0]   cfgActive,
  input  logic [31:0]   cfgHPorch,
  input  logic [31:0]   cfgVPorch,
  input  logic [31:0]   cfgTotal,
  input  logic [31:0]   cfgVsyncPos,
  input  logic [2:0]    cfgInvert,
  output logic          lineEnd,
  output logic          fieldEnd,
  output logic [CW-1:0] pixX,
  output logic [CW-1:0] pixY,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          frameDone
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [31:0] actQ, hPorQ, vPorQ, totQ, vsPosQ;
  logic [2:0]  invQ;
  logic [CW-1:0] xQ, yQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ <= '0; hPorQ <= '0; vPorQ <= '0; totQ <= '0; vsPosQ <= '0; invQ <= '0;
    end else if (strobe.loadCfg) begin
      actQ   <= cfgActive;
      hPorQ  <= cfgHPorch;
      vPorQ  <= cfgVPorch;
      totQ   <= cfgTotal;
      vsPosQ <= cfgVsyncPos;
      invQ   <= cfgInvert;
    end
  end

  logic unusedVsBits;
  assign unusedVsBits = ^{vsPosQ[15:12], vsPosQ[19:17]};

  logic [CW-1:0] hAct, vAct, rightM, leftM, hTot, vTotBase, backP, frontP;
  logic [CW-1:0] oddAdd, vTot, hsStart, hsEnd, vsStartLine, vsEndLine;
  logic [CW-1:0] halfLine, vsOnPix, vsOffPix;
  logic          offEn;

  always_comb begin
    hAct     = CW'(actQ[15:0]);
    vAct     = CW'(actQ[31:16]);
    rightM   = CW'(hPorQ[15:0]);
    leftM    = CW'(hPorQ[31:16]);
    hTot     = CW'(totQ[15:0]);
    vTotBase = CW'(totQ[31:16]);
    backP    = CW'(vPorQ[15:0]);
    frontP   = CW'(vPorQ[31:16]);
    oddAdd   = strobe.oddField ? ONE : '0;
    vTot        = vTotBase + oddAdd;
    vsStartLine = vAct + backP + oddAdd;
    vsEndLine   = vTot - frontP;
    hsStart     = hAct + rightM;
    hsEnd       = hTot - leftM;
    halfLine    = strobe.oddField ? (hTot >> 1) : '0;
    offEn       = vsPosQ[VSPOS_EN_BIT];
    vsOnPix     = offEn ? CW'(vsPosQ[VSPOS_ON_LSB +: VSPOS_W]) - halfLine : '0;
    vsOffPix    = offEn ? CW'(vsPosQ[VSPOS_W-1:0]) - halfLine : '0;
  end

  assign lineEnd  = (xQ == hTot - ONE);
  assign fieldEnd = (yQ == vTot - ONE);

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.run) begin
      xQ <= '0;
      yQ <= '0;
    end else if (strobe.lineWrap) begin
      xQ <= '0;
      yQ <= strobe.fieldWrap ? '0 : yQ + ONE;
    end else begin
      xQ <= xQ + ONE;
    end
  end

  logic hsAct, vsAct, afterStart, beforeEnd;
  always_comb begin
    afterStart = (yQ > vsStartLine) || ((yQ == vsStartLine) && (xQ >= vsOnPix));
    beforeEnd  = (yQ < vsEndLine)   || ((yQ == vsEndLine)   && (xQ < vsOffPix));
    hsAct      = strobe.run && (xQ >= hsStart) && (xQ < hsEnd);
    vsAct      = strobe.run && afterStart && beforeEnd;
  end

  assign pixX      = xQ;
  assign pixY      = yQ;
  assign de        = strobe.run && (xQ < hAct) && (yQ < vAct);
  assign hsync     = hsAct ^ invQ[0];
  assign vsync     = vsAct ^ invQ[1];
  assign csync     = (hsAct | vsAct) ^ invQ[2];
  assign frameDone = strobe.run && lineEnd && (yQ == vAct - ONE);

  // R1
  x_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && hTot != '0) |-> (xQ < hTot));

  // R1
  y_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.run) && strobe.run && (yQ != $past(yQ))) |-> $past(strobe.lineWrap));

  // R10
  idle_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (xQ == '0 && yQ == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && hTot > ONE) |=> !frameDone);
endmodule

// File: rtl/interlace_timing_gen.sv
module interlace_timing_gen
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          interlaced,
  input  logic [31:0]   cfgActive,
  input  logic [31:0]   cfgHPorch,
  input  logic [31:0]   cfgVPorch,
  input  logic [31:0]   cfgTotal,
  input  logic [31:0]   cfgVsyncPos,
  input  logic [2:0]    cfgInvert,
  output logic [CW-1:0] pixX,
  output logic [CW-1:0] pixY,
  output logic          de,
  output logic          blank,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          fieldOdd,
  output logic          frameDone
);
  vtgStrobe_t strobe;
  logic lineEnd, fieldEnd;

  vtg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .interlaced(interlaced),
    .lineEnd(lineEnd), .fieldEnd(fieldEnd), .strobe(strobe)
  );

  vtg_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgActive(cfgActive), .cfgHPorch(cfgHPorch), .cfgVPorch(cfgVPorch),
    .cfgTotal(cfgTotal), .cfgVsyncPos(cfgVsyncPos), .cfgInvert(cfgInvert),
    .lineEnd(lineEnd), .fieldEnd(fieldEnd), .pixX(pixX), .pixY(pixY),
    .de(de), .hsync(hsync), .vsync(vsync), .csync(csync), .frameDone(frameDone)
  );

  assign blank    = ~de;
  assign fieldOdd = strobe.oddField;

  // R2
  blank_de_chk: assert property (@(posedge clk) disable iff (!rstN)
    blank != de);
endmodule

// File: tb/tb_interlace_timing_gen.sv
module tb_interlace_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rstN, enable, interlaced;
  logic [31:0] cActive, cHPor, cVPor, cTot, cVsPos;
  logic [2:0]  cInv;
  logic [CW-1:0] pixX, pixY;
  logic de, blank, hsync, vsync, csync, fieldOdd, frameDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  interlace_timing_gen #(.CW(CW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .interlaced(interlaced),
    .cfgActive(cActive), .cfgHPorch(cHPor), .cfgVPorch(cVPor), .cfgTotal(cTot),
    .cfgVsyncPos(cVsPos), .cfgInvert(cInv), .pixX(pixX), .pixY(pixY),
    .de(de), .blank(blank), .hsync(hsync), .vsync(vsync), .csync(csync),
    .fieldOdd(fieldOdd), .frameDone(frameDone)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  int mx = 0, my = 0, modd = 0;
  logic [31:0] sAct = 0, sHPor = 0, sVPor = 0, sTot = 0, sVsPos = 0;
  logic [2:0]  sInv = 0;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d (x=%0d y=%0d)", req, what, act, exp, mx, my);
    end
  endtask

  task automatic tick();
    int ha, va, rm, lm, ht, vt, bp, fp, onP, offP, sl, el, pos;
    bit en, eDe, eHs, eVs, eDone;
    @(negedge clk);
    en = enable;
    ha = sAct & 'hFFF;  va = (sAct >> 16) & 'hFFF;
    rm = sHPor & 'hFFF; lm = (sHPor >> 16) & 'hFFF;
    ht = sTot & 'hFFF;  vt = ((sTot >> 16) & 'hFFF) + modd;
    bp = (sVPor & 'hFFF) + modd; fp = (sVPor >> 16) & 'hFFF;
    if (sVsPos[16]) begin
      onP = (sVsPos >> 20) & 'hFFF;
      offP = sVsPos & 'hFFF;
      if (modd != 0) begin onP -= ht / 2; offP -= ht / 2; end
    end else begin
      onP = 0; offP = 0;
    end
    sl = va + bp; el = vt - fp;
    pos = my * ht + mx;
    eDe   = en && mx < ha && my < va;
    eHs   = en && mx >= ha + rm && mx < ht - lm;
    eVs   = en && pos >= sl * ht + onP && pos < el * ht + offP;
    eDone = en && mx == ht - 1 && my == va - 1;
    chk("R1", "pixX", int'(pixX), mx);
    chk("R1", "pixY", int'(pixY), my);
    chk("R2 R10", "de", int'(de), int'(eDe));
    chk("R2", "blank", int'(blank), int'(!eDe));
    chk("R3 R7 R8", "hsync", int'(hsync), int'(eHs ^ sInv[0]));
    chk("R4 R5 R7", "vsync", int'(vsync), int'(eVs ^ sInv[1]));
    chk("R7", "csync", int'(csync), int'((eHs | eVs) ^ sInv[2]));
    chk("R6", "fieldOdd", int'(fieldOdd), modd);
    chk("R9", "frameDone", int'(frameDone), int'(eDone));
    // advance model
    if (!en) begin
      mx = 0; my = 0; modd = 0;
      sAct = cActive; sHPor = cHPor; sVPor = cVPor; sTot = cTot; sVsPos = cVsPos; sInv = cInv;
    end else if (mx == ht - 1) begin
      mx = 0;
      if (my == vt - 1) begin
        my = 0;
        modd = interlaced ? 1 - modd : 0;
        sAct = cActive; sHPor = cHPor; sVPor = cVPor; sTot = cTot; sVsPos = cVsPos; sInv = cInv;
      end else my++;
    end else mx++;
    @(posedge clk);
    #1;
  endtask

  task automatic runTicks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int prevVs;
    int rises;
    rstN = 0; enable = 0; interlaced = 0;
    cActive = {16'd4, 16'd8};  cHPor = {16'd3, 16'd2};
    cVPor   = {16'd2, 16'd1};  cTot  = {16'd9, 16'd16};
    cVsPos  = (32'd12 << 20) | (32'd1 << 16) | 32'd12;
    cInv    = 3'b000;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    // R10 reset state
    chk("R10", "reset de", int'(de), 0);
    chk("R10", "reset blank", int'(blank), 1);
    chk("R10", "reset hsync", int'(hsync), 0);
    chk("R10", "reset fieldOdd", int'(fieldOdd), 0);
    chk("R1", "reset pixX", int'(pixX), 0);
    runTicks(3);

    // progressive, two fields (R4)
    enable = 1;
    runTicks(2 * 144 + 5);

    // R8: mid-field change is deferred
    while (!(mx == 0 && my == 1)) tick();
    cHPor = {16'd3, 16'd1};
    cInv  = 3'b001;
    while (!(mx == 10 && my == 2)) tick();
    chk("R8", "hsync still old", int'(hsync), 1);
    runTicks(300);

    // interlaced with inversions (R5 R6 R7)
    interlaced = 1;
    cInv = 3'b110;
    runTicks(4 * 152 + 20);

    // offset disabled (R4 R5)
    cVsPos = (32'd12 << 20) | 32'd12;
    runTicks(3 * 152);

    // disable mid-field (R10)
    enable = 0;
    runTicks(2);
    chk("R10", "idle de", int'(de), 0);
    chk("R10", "idle blank", int'(blank), 1);
    chk("R10", "idle fieldOdd", int'(fieldOdd), 0);
    chk("R10", "idle hsync", int'(hsync), int'(cInv[0]));
    chk("R10", "idle vsync", int'(vsync), int'(cInv[1]));

    // R11: 2640-clock interlaced line, vsync pixel positions
    cActive = {16'd2, 16'd1920}; cHPor = {16'd148, 16'd528};
    cVPor   = {16'd1, 16'd1};    cTot  = {16'd5, 16'd2640};
    cVsPos  = (32'd2448 << 20) | (32'd1 << 16) | 32'd2448;
    cInv    = 3'b000;
    runTicks(2);
    enable = 1;
    prevVs = 0;
    rises = 0;
    for (int i = 0; i < 32000 && rises < 2; i++) begin
      tick();
      if (vsync && prevVs == 0) begin
        rises++;
        if (fieldOdd) chk("R11", "odd vsync pixel", int'(pixX), 1128);
        else          chk("R11", "even vsync pixel", int'(pixX), 2448);
      end
      prevVs = int'(vsync);
    end
    chk("R11", "vsync rises seen", rises, 2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule